// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block is a single-channel transmit DMA engine. It follows a chain of buffer descriptors kept in shared memory and copies each described buffer, byte by byte, into the transmit FIFO of a serial framer. When the host issues a start command and the initialise bit is set, the engine loads the base descriptor address and fetches that descriptor. It then streams the data section, whose start may be any byte address. When the descriptor asks for it, the engine marks the end of the frame. It writes a done mark back into the descriptor and then moves to the next descriptor.

Each descriptor carries a hold bit that stops the walk along the chain. A held descriptor parks the engine on itself. If that descriptor does not also close a frame, the engine aborts the frame in the framer and raises an error interrupt. A poll command re-reads the parked descriptor's control word. Once the host has cleared the hold bit, the engine resumes at the next pointer. A new start command restarts the engine from the base address.

Top module: `tdma_tx_engine`

## Requirements
- R1: A pulse on `cmd_start_i` while `cfg_init_i` is high and the engine is idle or parked loads `base_addr_i` and reads control word 0 at that address. A start while `cfg_init_i` is low, or while the engine is busy, is ignored.
- R2: Descriptor layout. Word 0 (at the descriptor address) holds the byte count in bits [15:0], hold in bit 31, frame end in bit 30, host interrupt in bit 29 and the done mark in bit 28. Word 1 (+4) holds the byte pointer to the data. Word 2 (+8) holds the next-descriptor pointer. The engine reads all three words, then the data words.
- R3: The data bytes reach the FIFO in address order, exactly byte-count of them, for any start offset. Byte lane k of a memory word is bits [8k+7:8k].
- R4: `fifo_wr_o` is never high while `fifo_full_i` is high, and no byte is lost or repeated across full periods.
- R5: For a frame-end descriptor, `fifo_eof_o` pulses once, on its own, after the last data byte of that section.
- R6: After the data, the engine writes word 0 back with bit 28 set and all other bits unchanged, before it reads any further descriptor.
- R7: One cycle after the writeback is accepted, `irq_frame_o` pulses for one cycle if the descriptor had frame end and `irq_frame_en_i` is high. `irq_host_o` pulses in the same way if the descriptor had the host-interrupt bit.
- R8: A descriptor with hold set parks the engine after its writeback, with no read of the next descriptor.
- R9: Hold without frame end pulses `fifo_abort_o` in the writeback accept cycle, and pulses `irq_err_o` in the next cycle.
- R10: While parked, a poll reads word 0 once. If hold is still set, the engine stays parked and raises no interrupt. If hold is clear, the engine follows the next pointer. A poll while idle is ignored.
- R11: A zero-length descriptor makes no FIFO data writes and reads no data words, but it is still written back as done.
- R12: Every memory address is word aligned, and a request holds its address and direction until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Host action request |
| cfg_init_i | input | 1 | Initialise-transmit configuration bit |
| cmd_poll_i | input | 1 | Host poll command |
| base_addr_i | input | 32 | Base descriptor byte address |
| irq_frame_en_i | input | 1 | Frame-complete interrupt enable |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Memory read data |
| fifo_wr_o | output | 1 | FIFO byte write |
| fifo_data_o | output | 8 | FIFO byte |
| fifo_eof_o | output | 1 | Frame-end marker pulse |
| fifo_abort_o | output | 1 | Underrun/abort pulse to framer |
| fifo_full_i | input | 1 | FIFO full |
| irq_frame_o | output | 1 | Frame-complete interrupt pulse |
| irq_host_o | output | 1 | Host-requested interrupt pulse |
| irq_err_o | output | 1 | Hold-without-frame-end error pulse |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses and words, byte-wide FIFO data and a 16-bit count field. The four byte lanes per word let a sweep over every start offset combined with lengths 0 to 9 reach zero-length, sub-word, word-crossing and three-word sections. The sweep also runs with and without FIFO-full and memory-stall patterns, and with frame end, host interrupt and the interrupt mask varied. A four-descriptor chain exercises following the next pointer, an abort on hold, a poll that finds hold still set, a poll that resumes the chain, and a start command that arrives while the engine is busy.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RDDATA, S_EMIT, S_EOF, S_WB, S_PARK, S_POLL
  } tdma_state_e;

  localparam int HOLD_BIT = 31;
  localparam int FE_BIT   = 30;
  localparam int HI_BIT   = 29;
  localparam int DONE_BIT = 28;
endpackage

// File: rtl/tdma_unpack.sv
module tdma_unpack #(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int LANES = DW / BW,
  localparam int LW = $clog2(LANES),
  localparam int NW = LW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic [LW-1:0] first_i,
  input  logic [NW-1:0] num_i,
  input  logic          full_i,
  output logic          wr_o,
  output logic [BW-1:0] byte_o,
  output logic          empty_o
);
  logic [DW-1:0] word_q;
  logic [LW-1:0] idx_q;
  logic [NW-1:0] left_q;

  assign empty_o = (left_q == '0);
  assign wr_o    = !empty_o && !full_i;
  assign byte_o  = word_q[idx_q*BW +: BW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      idx_q  <= first_i;
      left_q <= num_i;
    end else if (wr_o) begin
      idx_q  <= idx_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  // R3: a new word is only taken once the previous one is drained
  a_r3_load_when_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> empty_o);
  a_r3_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (num_i != '0 && num_i <= NW'(LANES)));
endmodule

// File: rtl/tdma_irq_reg.sv
module tdma_irq_reg #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[i] <= 1'b0;
      else         irq_o[i] <= ev_i[i];
    end
  end
endmodule

// File: rtl/tdma_tx_engine.sv
module tdma_tx_engine
  import tdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_start_i,
  input  logic          cfg_init_i,
  input  logic          cmd_poll_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          irq_frame_en_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          fifo_wr_o,
  output logic [BW-1:0] fifo_data_o,
  output logic          fifo_eof_o,
  output logic          fifo_abort_o,
  input  logic          fifo_full_i,
  output logic          irq_frame_o,
  output logic          irq_host_o,
  output logic          irq_err_o
);
  localparam int LANES = DW / BW;
  localparam int LW    = $clog2(LANES);
  localparam int NW    = LW + 1;
  localparam int STEP  = DW / 8;

  tdma_state_e   state_q;
  logic [AW-1:0] desc_q, next_q, ptr_q;
  logic [DW-1:0] w0_q;
  logic [CW-1:0] rem_q;

  logic          hold, fe, hi, start_ok, wb_done, up_load, up_empty;
  logic [LW-1:0] off;
  logic [NW-1:0] avail, num;
  logic [AW-1:0] aligned;

  assign hold     = w0_q[HOLD_BIT];
  assign fe       = w0_q[FE_BIT];
  assign hi       = w0_q[HI_BIT];
  assign off      = ptr_q[LW-1:0];
  assign avail    = NW'(LANES) - NW'(off);
  assign num      = (rem_q < CW'(avail)) ? NW'(rem_q) : avail;
  assign aligned  = {ptr_q[AW-1:LW], {LW{1'b0}}};
  assign start_ok = cmd_start_i && cfg_init_i && (state_q == S_IDLE || state_q == S_PARK);
  assign wb_done  = (state_q == S_WB) && mem_ack_i;
  assign up_load  = (state_q == S_RDDATA) && mem_ack_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_wdata_o = w0_q | (DW'(1) << DONE_BIT);
    unique case (state_q)
      S_RD0, S_POLL: mem_req_o = 1'b1;
      S_RD1:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + AW'(STEP);   end
      S_RD2:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + AW'(2*STEP); end
      S_RDDATA: begin mem_req_o = 1'b1; mem_addr_o = aligned; end
      S_WB:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      next_q  <= '0;
      ptr_q   <= '0;
      w0_q    <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE, S_PARK: begin
          if (start_ok) begin
            desc_q  <= base_addr_i;
            state_q <= S_RD0;
          end else if (state_q == S_PARK && cmd_poll_i) begin
            state_q <= S_POLL;
          end
        end
        S_RD0: if (mem_ack_i) begin
          w0_q    <= mem_rdata_i;
          rem_q   <= mem_rdata_i[CW-1:0];
          state_q <= S_RD1;
        end
        S_RD1: if (mem_ack_i) begin
          ptr_q   <= mem_rdata_i[AW-1:0];
          state_q <= S_RD2;
        end
        S_RD2: if (mem_ack_i) begin
          next_q  <= mem_rdata_i[AW-1:0];
          state_q <= (rem_q == '0) ? (fe ? S_EOF : S_WB) : S_RDDATA;
        end
        S_RDDATA: if (mem_ack_i) begin
          ptr_q   <= aligned + AW'(STEP);
          rem_q   <= rem_q - CW'(num);
          state_q <= S_EMIT;
        end
        S_EMIT: if (up_empty) begin
          state_q <= (rem_q == '0) ? (fe ? S_EOF : S_WB) : S_RDDATA;
        end
        S_EOF: state_q <= S_WB;
        S_WB: if (mem_ack_i) begin
          if (hold) state_q <= S_PARK;
          else begin
            desc_q  <= next_q;
            state_q <= S_RD0;
          end
        end
        S_POLL: if (mem_ack_i) begin
          if (mem_rdata_i[HOLD_BIT]) state_q <= S_PARK;
          else begin
            desc_q  <= next_q;
            state_q <= S_RD0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  tdma_unpack #(.DW(DW), .BW(BW)) u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (up_load),
    .word_i  (mem_rdata_i),
    .first_i (off),
    .num_i   (num),
    .full_i  (fifo_full_i),
    .wr_o    (fifo_wr_o),
    .byte_o  (fifo_data_o),
    .empty_o (up_empty)
  );

  assign fifo_eof_o   = (state_q == S_EOF);
  assign fifo_abort_o = wb_done && hold && !fe;

  tdma_irq_reg #(.N(3)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   ({wb_done && fe && irq_frame_en_i, wb_done && hi, fifo_abort_o}),
    .irq_o  ({irq_frame_o, irq_host_o, irq_err_o})
  );

  a_r4_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !fifo_full_i);
  a_r5_eof_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_eof_o |-> (!fifo_wr_o && !mem_req_o));
  a_r9_abort_then_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_abort_o |=> irq_err_o);
  a_r7_frame_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_frame_o |=> !irq_frame_o);
  a_r12_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[LW-1:0] == '0));
  a_r12_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: tb/tb_tdma_tx_engine.sv
`timescale 1ns/1ps
module tb_tdma_tx_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 0, init = 0, poll = 0, frame_en = 1;
  logic [31:0] base = 0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        fifo_wr, fifo_eof, fifo_abort, fifo_full;
  logic [7:0]  fifo_data;
  logic        irq_frame, irq_host, irq_err;

  tdma_tx_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(start), .cfg_init_i(init), .cmd_poll_i(poll),
    .base_addr_i(base), .irq_frame_en_i(frame_en),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .fifo_eof_o(fifo_eof),
    .fifo_abort_o(fifo_abort), .fifo_full_i(fifo_full),
    .irq_frame_o(irq_frame), .irq_host_o(irq_host), .irq_err_o(irq_err));

  // memory model: host image plus generation-tagged writeback shadow
  logic [31:0] mem  [0:127];
  logic [31:0] wmem [0:127];
  int          wgen [0:127];
  int          gen = 1;
  int          cyc = 0;
  logic        stall_en = 0, full_en = 0;

  always @(posedge clk) cyc <= cyc + 1;
  assign mem_ack   = mem_req && !(stall_en && (cyc % 3 == 1));
  assign fifo_full = full_en && (cyc % 5 == 2 || cyc % 5 == 3);
  assign mem_rdata = (wgen[mem_addr[8:2]] == gen) ? wmem[mem_addr[8:2]] : mem[mem_addr[8:2]];

  int n_got = 0, eof_cnt = 0, eof_pos = -1, abort_cnt = 0, rd_cnt = 0, wb_cnt = 0;
  int frame_cnt = 0, host_cnt = 0, err_cnt = 0, bad_full = 0, bad_align = 0;
  logic [31:0] last_wb;
  logic [7:0]  got [0:63];

  initial for (int i = 0; i < 128; i++) wgen[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack && mem_we) begin
        wmem[mem_addr[8:2]] = mem_wdata;
        wgen[mem_addr[8:2]] = gen;
        last_wb = mem_wdata;
        wb_cnt++;
      end
      if (mem_req && mem_ack && !mem_we) rd_cnt++;
      if (mem_req && mem_addr[1:0] != 2'b00) bad_align++;
      if (fifo_eof) begin eof_cnt++; eof_pos = n_got; end
      if (fifo_wr) begin
        if (fifo_full) bad_full++;
        if (n_got < 64) got[n_got] = fifo_data;
        n_got++;
      end
      if (fifo_abort) abort_cnt++;
      if (irq_frame) frame_cnt++;
      if (irq_host) host_cnt++;
      if (irq_err) err_cnt++;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic clear_counts();
    n_got = 0; eof_cnt = 0; eof_pos = -1; abort_cnt = 0; rd_cnt = 0; wb_cnt = 0;
    frame_cnt = 0; host_cnt = 0; err_cnt = 0;
  endtask

  task automatic pulse_start(input logic [31:0] b, input logic in);
    @(negedge clk); base = b; init = in; start = 1;
    @(negedge clk); start = 0; init = 0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic wait_wb(input int target);
    for (int t = 0; t < 3000 && wb_cnt < target; t++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // compare captured bytes [from, from+len) against pattern starting at byte address a
  task automatic chk_bytes(input int from, input int len, input int a, input string rq);
    int bad = 0;
    for (int i = 0; i < len; i++) if (got[from+i] != pat(a + i)) bad++;
    chk(bad == 0, rq, bad, 0);
  endtask

  initial begin
    int dog = 0;
    while (dog < 150000) begin @(posedge clk); dog++; end
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=%0d expected=%0d", dog, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 128; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (3) @(negedge clk);
    // reset state
    chk(!mem_req && !fifo_wr && !fifo_eof && !fifo_abort, "reset outputs", mem_req, 0);
    chk(!irq_frame && !irq_host && !irq_err, "reset irq", irq_err, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R10 poll in idle, R1 start without init: both ignored
    clear_counts();
    pulse_poll();
    pulse_start(32'h0, 1'b0);
    repeat (10) @(negedge clk);
    chk(rd_cnt == 0 && n_got == 0, "R1/R10 idle ignore", rd_cnt, 0);

    // sweep: every offset x lengths 0..9, single held descriptor
    for (int off = 0; off < 4; off++) begin
      for (int len = 0; len < 10; len++) begin
        bit fe = (len % 3 != 1);
        bit hi = len[0];
        int exp_rd;
        stall_en = off[0];
        full_en  = (len % 2 == 0);
        frame_en = (off != 3);
        gen++;
        mem[0] = {1'b1, fe, hi, 13'b0, 16'(len)};
        mem[1] = 32'h100 + 32'(off);
        mem[2] = 32'h0C0;
        clear_counts();
        pulse_start(32'h0, 1'b1);
        wait_wb(1);
        exp_rd = 3 + ((len == 0) ? 0 : (off + len + 3) / 4);
        chk(n_got == len, "R3 byte count", n_got, len);
        chk_bytes(0, len, 32'h100 + off, "R3 byte order");
        chk(rd_cnt == exp_rd, "R2/R11 reads", rd_cnt, exp_rd);
        chk(eof_cnt == int'(fe), "R5 eof count", eof_cnt, int'(fe));
        if (fe) chk(eof_pos == len, "R5 eof after last byte", eof_pos, len);
        chk(wb_cnt == 1 && last_wb == (mem[0] | 32'h1000_0000), "R6 writeback",
            int'(last_wb), int'(mem[0] | 32'h1000_0000));
        chk(frame_cnt == int'(fe && frame_en), "R7 frame irq", frame_cnt, int'(fe && frame_en));
        chk(host_cnt == int'(hi), "R7 host irq", host_cnt, int'(hi));
        chk(abort_cnt == int'(!fe) && err_cnt == int'(!fe), "R9 abort/err",
            abort_cnt + err_cnt, 2 * int'(!fe));
      end
    end
    chk(bad_full == 0, "R4 no write while full", bad_full, 0);

    // chain: A(5B,no FE) -> B(3B,FE) -> C(2B,hold,no FE) -> D(4B,FE,hold)
    stall_en = 1; full_en = 1; frame_en = 1;
    gen++;
    mem[0]  = {3'b001, 13'b0, 16'd5}; mem[1]  = 32'h101; mem[2]  = 32'h10;
    mem[4]  = {3'b010, 13'b0, 16'd3}; mem[5]  = 32'h140; mem[6]  = 32'h20;
    mem[8]  = {3'b100, 13'b0, 16'd2}; mem[9]  = 32'h180; mem[10] = 32'h30;
    mem[12] = {3'b110, 13'b0, 16'd4}; mem[13] = 32'h1C2; mem[14] = 32'h40;
    mem[32] = 32'h0;
    clear_counts();
    pulse_start(32'h0, 1'b1);
    repeat (2) @(negedge clk);
    pulse_start(32'h80, 1'b1);  // busy: must be ignored
    wait_wb(3);
    chk(n_got == 10, "R1/R8 chain bytes", n_got, 10);
    chk_bytes(0, 5, 32'h101, "R3 chain A");
    chk_bytes(5, 3, 32'h140, "R3 chain B");
    chk_bytes(8, 2, 32'h180, "R3 chain C");
    chk(eof_cnt == 1 && eof_pos == 8, "R5 chain eof", eof_pos, 8);
    chk(abort_cnt == 1 && err_cnt == 1, "R9 chain abort", abort_cnt + err_cnt, 2);
    chk(frame_cnt == 1 && host_cnt == 1, "R7 chain irq", frame_cnt + host_cnt, 2);
    chk(wb_cnt == 3 && rd_cnt == 3 * 3 + 2 + 1 + 1, "R8 parked, no next read", rd_cnt, 13);

    // R10 poll with hold still set
    pulse_poll();
    repeat (10) @(negedge clk);
    chk(rd_cnt == 14, "R10 poll reads once", rd_cnt, 14);
    chk(wb_cnt == 3 && n_got == 10 && err_cnt == 1 && frame_cnt == 1,
        "R10 stays parked, no irq", err_cnt + frame_cnt, 2);

    // R10 host clears hold, poll resumes at next pointer
    mem[8] = {3'b000, 13'b0, 16'd2};
    gen++;
    pulse_poll();
    wait_wb(4);
    chk(n_got == 14, "R10 resume bytes", n_got, 14);
    chk_bytes(10, 4, 32'h1C2, "R10 resume data D");
    chk(eof_cnt == 2 && eof_pos == 14, "R10 resume eof", eof_pos, 14);
    chk(frame_cnt == 2 && abort_cnt == 1, "R10 resume irq", frame_cnt, 2);
    chk(bad_full == 0, "R4 chain no write while full", bad_full, 0);
    chk(bad_align == 0, "R12 aligned addresses", bad_align, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule